// File: doc/BRIEF.md
# Event Timer Interrupt Router

This block sits behind the comparators of a multi-channel event timer. It turns each channel's match pulse into an interrupt. The kind of interrupt depends on that channel's configuration word. A channel can drive a held level on one of several interrupt lines, emit a one-cycle pulse on a line, or post a message-signalled interrupt. A message interrupt is an address/data write request that stays raised until the downstream fabric acknowledges it.

Each channel has a status bit that records an outstanding level interrupt. Software clears it by writing ones. The block also clears it by itself when a configuration write would otherwise leave the line asserted forever. Before a routing line number is stored, it is checked against a permitted-lines mask. That mask is derived from the number of interrupt lines and is read back in the upper half of each configuration word. When several channels select the same line, the line carries the OR of their contributions. Line number 0 means the channel is not routed.

Top module: `tirq_router`

## Requirements
- R1: After reset all status bits are 0, every interrupt line is low, no message request is raised, and each configuration reads back as the permitted-lines mask in bits 63:32, with bit 15 equal to the MSG_CAP parameter and every other bit 0.
- R2: A configuration write stores bits 31:0 as written, with two exceptions: bit 15 is read-only and keeps the MSG_CAP value, and the routing field may be reset under R3. The fields are: bit 1 selects level (1) or edge (0), bit 2 enables the interrupt, bits 13:9 hold the routing line, and bit 14 enables message delivery.
- R3: When message delivery is not active and the written routing line is non-zero, the routing field (bits 13:9) is stored as 0 unless the permitted-lines mask has that line's bit set.
- R4: A match on a channel whose enable bit (bit 2) is clear changes no status bit, line or message request.
- R5: An enabled edge channel with a non-zero effective route drives its line high for exactly the one cycle after the clock edge that samples the match.
- R6: An enabled level channel with a non-zero effective route sets its status bit on the edge that samples the match and holds its line high while the bit is set. A match while the bit is already set has no effect.
- R7: Writing 1 to a set status bit clears it on that edge and drops its line. Writing 0, or writing 1 to a clear bit, has no effect.
- R8: A configuration write clears a channel's status bit when the new word disables the interrupt, selects edge mode, activates message delivery, or changes the effective routing line.
- R9: Message delivery is active only when both bit 15 and bit 14 are 1. A match then raises a request that carries bits 63:32 of the channel's message register as the address and bits 31:0 as the data. The request holds until acknowledged, and the lowest-numbered pending channel is presented. A match while that channel's request is pending is dropped.
- R10: A channel in message mode, or with routing line 0, never drives any interrupt line. Line 0 is always low.
- R11: Each interrupt line is the OR of the level status bits and edge pulses of all channels whose effective route is that line.
- R12: The permitted-lines mask is lines 24 to 31 when there are 32 or more lines, the top four lines when there are 20 to 31 lines, and empty with fewer than 20 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| match_i | input | N_TMR | Per-channel match pulse from the comparators |
| cfg_we_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | SEL_W | Channel addressed by configuration or message writes |
| cfg_wdata_i | input | 32 | Configuration write data (bits 31:0) |
| msg_we_i | input | 1 | Message register write strobe |
| msg_wdata_i | input | 64 | Message register data: address in 63:32, data in 31:0 |
| clr_we_i | input | 1 | Status write-one-to-clear strobe |
| clr_i | input | N_TMR | Status bits to clear |
| rd_sel_i | input | SEL_W | Channel whose configuration appears on rd_cfg_o |
| rd_cfg_o | output | 64 | Configuration readback: permitted mask in 63:32, stored word in 31:0 |
| sts_o | output | N_TMR | Level status bits |
| irq_line_o | output | N_LINES | Interrupt lines |
| msg_req_o | output | 1 | Message interrupt request |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |
| msg_ack_i | input | 1 | Acknowledge of the presented request |

## Verification
Every stored effect is due one clock edge after the stimulus that causes it. This covers status set and clear, the edge pulse, the pending message request and the stored configuration. Lines, status, the request and its address/data follow the registers combinationally, and configuration readback follows rd_sel_i with no delay. The bench drives inputs on the falling edge and advances its reference model at the next rising edge. It compares every output at the falling edge after that, so each result is sampled in the cycle it is due. A one-cycle pulse that lasts too long or shows up a cycle late therefore fails at once.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int B_LVL  = 1;
  localparam int B_EN   = 2;
  localparam int B_RLO  = 9;
  localparam int RT_W   = 5;
  localparam int B_MEN  = 14;
  localparam int B_MCAP = 15;

  // Permitted routing lines as a function of the number of lines available.
  function automatic logic [31:0] perm_mask(input int n_lines);
    if (n_lines >= 32)      return 32'hFF00_0000;
    else if (n_lines >= 20) return 32'h0000_000F << (n_lines - 4);
    else                    return 32'h0;
  endfunction

  function automatic logic is_msg(input logic [31:0] c);
    return c[B_MCAP] & c[B_MEN];
  endfunction

  function automatic logic [RT_W-1:0] eff_route(input logic [31:0] c);
    return is_msg(c) ? '0 : c[B_RLO +: RT_W];
  endfunction

  // Force the read-only capability bit and drop a routing line outside the mask.
  function automatic logic [31:0] sanitize(input logic [31:0] w,
                                           input logic [31:0] perm,
                                           input logic        cap);
    logic [31:0] r;
    r = w;
    r[B_MCAP] = cap;
    if (!is_msg(r) && (r[B_RLO +: RT_W] != '0) && !perm[r[B_RLO +: RT_W]])
      r[B_RLO +: RT_W] = '0;
    return r;
  endfunction
endpackage

// File: rtl/tirq_chan.sv
module tirq_chan
  import tirq_pkg::*;
#(
  parameter logic [31:0] PERM    = 32'h0,
  parameter bit          MSG_CAP = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                match_i,
  input  logic                cfg_we_i,
  input  logic [31:0]         cfg_wdata_i,
  input  logic                msg_we_i,
  input  logic [63:0]         msg_wdata_i,
  input  logic                clr_i,
  input  logic                ack_i,
  output logic [31:0]         cfg_o,
  output logic                sts_o,
  output logic                pulse_o,
  output logic                pend_o,
  output logic [RT_W-1:0]     route_o,
  output logic [63:0]         msg_o
);
  localparam logic [31:0] CFG_RST = 32'(MSG_CAP) << B_MCAP;

  logic [31:0] cfg_q;
  logic        sts_q, pulse_q, pend_q;
  logic [63:0] msg_q;

  // Named internal events
  logic        fire, take_level, take_edge, take_msg, cfg_drop;
  logic [31:0] cfg_new;

  assign route_o    = eff_route(cfg_q);
  assign fire       = match_i & cfg_q[B_EN] & ~sts_q;
  assign take_msg   = fire & is_msg(cfg_q) & ~pend_q;
  assign take_level = fire & (route_o != '0) & cfg_q[B_LVL];
  assign take_edge  = fire & (route_o != '0) & ~cfg_q[B_LVL];
  assign cfg_new    = sanitize(cfg_wdata_i, PERM, MSG_CAP);
  assign cfg_drop   = cfg_we_i & (~cfg_new[B_EN] | is_msg(cfg_new) | ~cfg_new[B_LVL]
                                  | (eff_route(cfg_new) != route_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
      pend_q  <= 1'b0;
      msg_q   <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_new;
      if (msg_we_i) msg_q <= msg_wdata_i;
      sts_q   <= cfg_drop ? 1'b0 : ((sts_q & ~clr_i) | take_level);
      pulse_q <= take_edge;
      pend_q  <= (pend_q & ~ack_i) | take_msg;
    end
  end

  assign cfg_o   = cfg_q;
  assign sts_o   = sts_q;
  assign pulse_o = pulse_q;
  assign pend_o  = pend_q;
  assign msg_o   = msg_q;

  AST_STS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q |-> (cfg_q[B_EN] && cfg_q[B_LVL] && route_o != '0)); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(match_i)); // R5
  AST_ROUTE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (route_o != '0) |-> PERM[route_o]); // R3
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && clr_i) |=> !sts_q); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_i) |=> pend_q); // R9
endmodule

// File: rtl/tirq_linemux.sv
module tirq_linemux
  import tirq_pkg::*;
#(
  parameter int N_TMR   = 4,
  parameter int N_LINES = 24
) (
  input  logic [N_TMR-1:0]           sts_i,
  input  logic [N_TMR-1:0]           pulse_i,
  input  logic [N_TMR-1:0][RT_W-1:0] route_i,
  output logic [N_LINES-1:0]         line_o
);
  assign line_o[0] = 1'b0;

  for (genvar l = 1; l < N_LINES; l++) begin : g_line
    always_comb begin
      line_o[l] = 1'b0;
      for (int t = 0; t < N_TMR; t++)
        if (route_i[t] == RT_W'(l)) line_o[l] = line_o[l] | sts_i[t] | pulse_i[t];
    end
  end
endmodule

// File: rtl/tirq_msgarb.sv
module tirq_msgarb #(
  parameter int N_TMR = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_TMR-1:0]       pend_i,
  input  logic [N_TMR-1:0][63:0] msg_i,
  input  logic                   ack_i,
  output logic                   req_o,
  output logic [31:0]            addr_o,
  output logic [31:0]            data_o,
  output logic [N_TMR-1:0]       ack_o
);
  logic [N_TMR-1:0] grant;

  // Lowest-numbered pending channel wins.
  always_comb begin
    grant = '0;
    for (int t = N_TMR - 1; t >= 0; t--)
      if (pend_i[t]) grant = N_TMR'(1) << t;
  end

  always_comb begin
    addr_o = '0;
    data_o = '0;
    for (int t = 0; t < N_TMR; t++)
      if (grant[t]) begin
        addr_o = msg_i[t][63:32];
        data_o = msg_i[t][31:0];
      end
  end

  assign req_o = |pend_i;
  assign ack_o = grant & {N_TMR{ack_i}};

  AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o); // R9
endmodule

// File: rtl/tirq_router.sv
module tirq_router
  import tirq_pkg::*;
#(
  parameter int N_TMR   = 4,
  parameter int N_LINES = 24,
  parameter bit MSG_CAP = 1'b1,
  localparam int SEL_W  = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TMR-1:0]   match_i,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [31:0]        cfg_wdata_i,
  input  logic               msg_we_i,
  input  logic [63:0]        msg_wdata_i,
  input  logic               clr_we_i,
  input  logic [N_TMR-1:0]   clr_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [63:0]        rd_cfg_o,
  output logic [N_TMR-1:0]   sts_o,
  output logic [N_LINES-1:0] irq_line_o,
  output logic               msg_req_o,
  output logic [31:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  input  logic               msg_ack_i
);
  localparam logic [31:0] PERM = perm_mask(N_LINES);

  logic [N_TMR-1:0]           pulse, pend, ackv;
  logic [N_TMR-1:0][RT_W-1:0] route;
  logic [N_TMR-1:0][63:0]     msg;
  logic [N_TMR-1:0][31:0]     cfg;

  for (genvar t = 0; t < N_TMR; t++) begin : g_ch
    tirq_chan #(.PERM(PERM), .MSG_CAP(MSG_CAP)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .match_i    (match_i[t]),
      .cfg_we_i   (cfg_we_i && wr_sel_i == SEL_W'(t)),
      .cfg_wdata_i(cfg_wdata_i),
      .msg_we_i   (msg_we_i && wr_sel_i == SEL_W'(t)),
      .msg_wdata_i(msg_wdata_i),
      .clr_i      (clr_we_i & clr_i[t]),
      .ack_i      (ackv[t]),
      .cfg_o      (cfg[t]),
      .sts_o      (sts_o[t]),
      .pulse_o    (pulse[t]),
      .pend_o     (pend[t]),
      .route_o    (route[t]),
      .msg_o      (msg[t])
    );
  end

  tirq_linemux #(.N_TMR(N_TMR), .N_LINES(N_LINES)) u_mux (
    .sts_i  (sts_o),
    .pulse_i(pulse),
    .route_i(route),
    .line_o (irq_line_o)
  );

  tirq_msgarb #(.N_TMR(N_TMR)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_i(pend),
    .msg_i (msg),
    .ack_i (msg_ack_i),
    .req_o (msg_req_o),
    .addr_o(msg_addr_o),
    .data_o(msg_data_o),
    .ack_o (ackv)
  );

  always_comb begin
    rd_cfg_o = {PERM, 32'h0};
    for (int t = 0; t < N_TMR; t++)
      if (rd_sel_i == SEL_W'(t)) rd_cfg_o[31:0] = cfg[t];
  end

  AST_LINE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_line_o[0]); // R10
endmodule

// File: tb/sim_tirq_router.sv
`timescale 1ns/1ps
module sim_tirq_router;
  localparam int N = 4;
  localparam int NL = 24;
  localparam bit CAP = 1'b1;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]  match;
  logic          cfg_we, msg_we, clr_we, ack;
  logic [SW-1:0] wr_sel, rd_sel;
  logic [31:0]   cfg_wd;
  logic [63:0]   msg_wd;
  logic [N-1:0]  clr;
  logic [63:0]   rd_cfg;
  logic [N-1:0]  sts;
  logic [NL-1:0] lines;
  logic          req;
  logic [31:0]   addr, data;

  tirq_router #(.N_TMR(N), .N_LINES(NL), .MSG_CAP(CAP)) u0 (
    .clk(clk), .rst_n(rst_n), .match_i(match), .cfg_we_i(cfg_we), .wr_sel_i(wr_sel),
    .cfg_wdata_i(cfg_wd), .msg_we_i(msg_we), .msg_wdata_i(msg_wd), .clr_we_i(clr_we),
    .clr_i(clr), .rd_sel_i(rd_sel), .rd_cfg_o(rd_cfg), .sts_o(sts), .irq_line_o(lines),
    .msg_req_o(req), .msg_addr_o(addr), .msg_data_o(data), .msg_ack_i(ack));

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0]  m_cfg [N];
  logic [63:0]  m_msg [N];
  logic [N-1:0] m_sts, m_pulse, m_pend;

  function automatic logic [31:0] bench_mask(input int n);
    logic [31:0] m = '0;
    for (int l = 0; l < 32; l++)
      if ((n >= 32 && l >= 24) || (n >= 20 && n < 32 && l >= n - 4 && l < n)) m[l] = 1'b1;
    return m;
  endfunction

  function automatic bit msgm(input logic [31:0] c);
    return c[15] && c[14];
  endfunction

  function automatic int rte(input logic [31:0] c);
    return msgm(c) ? 0 : int'(c[13:9]);
  endfunction

  function automatic logic [31:0] mk(input bit en, input bit lvl, input bit men, input int rt);
    logic [31:0] c = '0;
    c[2] = en; c[1] = lvl; c[14] = men; c[13:9] = rt[4:0];
    return c;
  endfunction

  function automatic logic [NL-1:0] exp_lines();
    logic [NL-1:0] v = '0;
    for (int t = 0; t < N; t++)
      if ((m_sts[t] || m_pulse[t]) && rte(m_cfg[t]) != 0 && rte(m_cfg[t]) < NL)
        v[rte(m_cfg[t])] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic check_all();
    int sel = -1;
    for (int t = N - 1; t >= 0; t--) if (m_pend[t]) sel = t;
    chk("R5 R6 R10 R11 lines", 64'(lines), 64'(exp_lines()));
    chk("R4 R6 R7 R8 status", 64'(sts), 64'(m_sts));
    chk("R9 request", 64'(req), 64'(m_pend != '0));
    if (sel >= 0) chk("R9 address/data", {addr, data}, m_msg[sel]);
    chk("R2 R3 config", rd_cfg, {bench_mask(NL), m_cfg[rd_sel]});
  endtask

  task automatic idle();
    match = '0; cfg_we = 0; msg_we = 0; clr_we = 0; clr = '0; ack = 0;
    wr_sel = '0; cfg_wd = '0; msg_wd = '0;
  endtask

  task automatic step();
    logic [31:0]  n_cfg [N];
    logic [63:0]  n_msg [N];
    logic [N-1:0] n_sts, n_pulse, n_pend;
    int sel = -1;
    for (int t = N - 1; t >= 0; t--) if (m_pend[t]) sel = t;
    for (int t = 0; t < N; t++) begin
      logic [31:0] c = m_cfg[t];
      bit f = match[t] && c[2] && !m_sts[t];
      bit routed = rte(c) != 0;
      n_cfg[t] = c; n_msg[t] = m_msg[t];
      n_pulse[t] = f && routed && !c[1];
      n_pend[t]  = (m_pend[t] && !(ack && sel == t)) || (f && msgm(c) && !m_pend[t]);
      n_sts[t]   = (m_sts[t] && !(clr_we && clr[t])) || (f && routed && c[1]);
      if (msg_we && int'(wr_sel) == t) n_msg[t] = msg_wd;
      if (cfg_we && int'(wr_sel) == t) begin
        logic [31:0] w = cfg_wd;
        w[15] = CAP;
        if (!msgm(w) && w[13:9] != 0 && !bench_mask(NL)[w[13:9]]) w[13:9] = '0;
        n_cfg[t] = w;
        if (!w[2] || msgm(w) || !w[1] || rte(w) != rte(c)) n_sts[t] = 1'b0;
      end
    end
    @(posedge clk);
    m_sts = n_sts; m_pulse = n_pulse; m_pend = n_pend;
    for (int t = 0; t < N; t++) begin m_cfg[t] = n_cfg[t]; m_msg[t] = n_msg[t]; end
    @(negedge clk);
    idle();
    check_all();
  endtask

  task automatic wcfg(input int t, input logic [31:0] c);
    cfg_we = 1; wr_sel = SW'(t); cfg_wd = c; step();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle(); rd_sel = '0;
    m_sts = '0; m_pulse = '0; m_pend = '0;
    for (int t = 0; t < N; t++) begin m_cfg[t] = 32'(CAP) << 15; m_msg[t] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R12 mask derivation
    chk("R1 status", 64'(sts), 64'h0);
    chk("R1 lines", 64'(lines), 64'h0);
    chk("R1 request", 64'(req), 64'h0);
    for (int t = 0; t < N; t++) begin
      rd_sel = SW'(t); #0.1;
      chk("R1 config", rd_cfg, {bench_mask(NL), 32'h0000_8000});
    end
    chk("R12 mask", 64'(rd_cfg[63:32]), 64'h00F0_0000);
    rd_sel = '0;

    // R6 level on line 20; repeat match ignored; R7 write zero then one
    wcfg(0, mk(1, 1, 0, 20));
    match = 4'b0001; step();
    match = 4'b0001; step();
    clr_we = 1; clr = 4'b1110; step();
    clr_we = 1; clr = 4'b0001; step();
    // R5 edge pulse on line 21, R11 sharing line 21 with a level channel
    rd_sel = 2'd1;
    wcfg(1, mk(1, 0, 0, 21));
    match = 4'b0010; step();
    step();
    wcfg(0, mk(1, 1, 0, 21));
    match = 4'b0011; step();
    step();
    // R8 switch channel 0 to edge clears status
    wcfg(0, mk(1, 0, 0, 21));
    // R3 invalid route 5 reset to 0; R10 route 0 silent
    rd_sel = 2'd2;
    wcfg(2, mk(1, 1, 0, 5));
    match = 4'b0100; step();
    // R4 disabled channel ignores matches
    wcfg(2, mk(0, 1, 0, 22));
    match = 4'b0100; step();
    // R9 message mode on channels 3 and 2
    rd_sel = 2'd3;
    msg_we = 1; wr_sel = 2'd3; msg_wd = 64'hFEE0_1000_0000_00A3; step();
    msg_we = 1; wr_sel = 2'd2; msg_wd = 64'hFEE0_2000_0000_00B2; step();
    wcfg(3, mk(1, 0, 1, 23));
    wcfg(2, mk(1, 1, 1, 0));
    match = 4'b1000; step();
    step();
    match = 4'b1100; step();
    ack = 1; step();
    ack = 1; step();
    // R8 level channel moved to another line loses its status
    wcfg(0, mk(1, 1, 0, 22));
    match = 4'b0001; step();
    wcfg(0, mk(1, 1, 0, 23));

    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 5));
      match = N'($urandom) & N'($urandom);
      if ($urandom_range(0, 9) == 0) begin
        cfg_we = 1; wr_sel = SW'($urandom);
        cfg_wd = $urandom;
        cfg_wd[13:9] = (r == 0) ? 5'd0 : (r == 5) ? 5'($urandom) : 5'(19 + r);
        cfg_wd[14] = ($urandom_range(0, 3) == 0);
        cfg_wd[2] = ($urandom_range(0, 4) != 0);
      end else if ($urandom_range(0, 9) == 0) begin
        msg_we = 1; wr_sel = SW'($urandom); msg_wd = {$urandom, $urandom};
      end
      if ($urandom_range(0, 4) == 0) begin clr_we = 1; clr = N'($urandom); end
      ack = (m_pend != '0) && $urandom_range(0, 1) == 1;
      rd_sel = SW'($urandom);
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule